// File: doc/BRIEF.md
# Signal Monitor Serial Frame Transmitter

This block sends the results of a two-channel signal monitor over a three-wire serial link. It is always the master and drives the serial clock, the frame sync and the data line. Each channel provides three result words: a 20-bit RMS/mean-square magnitude, a 16-bit peak level and a 16-bit threshold-crossing count. Three enable bits choose which of these go into a frame. The same selection applies to both channels, so the frame length changes with the enables.

A start strobe begins a frame. The block latches every result word and the enables at that point, so the link always carries one consistent snapshot. The serial clock is the system clock divided by 2, 4 or 8. When a frame is idle the serial clock either keeps running or is held low, as the sleep bit selects.

Top module: `monitor_frame_tx`

## Requirements
- R1: The serial clock period is 2, 4 or 8 system clocks for `div_sel` equal to 0, 1 or 2, and 8 system clocks for `div_sel` equal to 3.
- R2: `ser_sync` and `ser_data` change only in the system clock cycle where `ser_clk` rises. The one exception is the drop of `ser_data` to low at the end of a frame.
- R3: The first serial clock rise after an accepted start raises `ser_sync`, which stays high for exactly one serial clock period. The first data bit appears at the next rise, with `ser_sync` low.
- R4: Each rise then presents one bit, MSB first. Channel A's fields come first, then channel B's. Within a channel the order is RMS (20 bits), then peak (16 bits), then threshold (16 bits). `field_en[2]` enables RMS, `field_en[1]` enables peak and `field_en[0]` enables threshold, and a disabled field is skipped.
- R5: With `field_en` equal to 0, a start produces a frame made only of the sync period, after which `busy` falls.
- R6: With `sclk_sleep` high, `ser_clk` stays low while no frame is pending or in progress. With it low, `ser_clk` toggles continuously.
- R7: A start strobe while `busy` is high has no effect: the current frame is not altered and no second frame follows.
- R8: `busy` rises in the cycle after an accepted start. It stays high until the serial clock rise that follows the last data bit.
- R9: The field values and enables are captured when the start is accepted. Changes to them during the frame do not alter the bits sent.
- R10: After reset all outputs are low, and `ser_data` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start strobe |
| field_en | input | 3 | Field enables: [2] RMS, [1] peak, [0] threshold |
| div_sel | input | 2 | Serial clock divide select |
| sclk_sleep | input | 1 | Hold serial clock low when idle |
| a_rms | input | RMS_W | Channel A RMS/mean-square word |
| a_peak | input | PK_W | Channel A peak word |
| a_thr | input | TH_W | Channel A threshold count |
| b_rms | input | RMS_W | Channel B RMS/mean-square word |
| b_peak | input | PK_W | Channel B peak word |
| b_thr | input | TH_W | Channel B threshold count |
| ser_clk | output | 1 | Serial clock |
| ser_sync | output | 1 | Frame sync |
| ser_data | output | 1 | Serial data |
| busy | output | 1 | Frame pending or in progress |

## Verification
The hardest case to reach from the ports is a frame disturbed in the middle. This covers both a second start and a full change of every result word while bits are still being shifted. The slowest divide is selected so that there is room between two serial clock rises. Right after the sixth data bit, the stimulus inverts all field inputs and pulses start. The captured stream must still equal the original snapshot, and the link must stay quiet after the frame ends. A separate case uses the empty field selection to exercise the sync-only frame, where the frame ends at the rise after the sync.

// File: rtl/monitor_frame_tx.sv
module monitor_frame_tx #(
  parameter int RMS_W = 20,
  parameter int PK_W  = 16,
  parameter int TH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       field_en,
  input  logic [1:0]       div_sel,
  input  logic             sclk_sleep,
  input  logic [RMS_W-1:0] a_rms,
  input  logic [PK_W-1:0]  a_peak,
  input  logic [TH_W-1:0]  a_thr,
  input  logic [RMS_W-1:0] b_rms,
  input  logic [PK_W-1:0]  b_peak,
  input  logic [TH_W-1:0]  b_thr,
  output logic             ser_clk,
  output logic             ser_sync,
  output logic             ser_data,
  output logic             busy
);
  localparam int CH_W = RMS_W + PK_W + TH_W;
  localparam int FR_W = 2 * CH_W;
  localparam int CW   = $clog2(FR_W + 1);

  logic [CH_W-1:0] pa, pb;
  logic [CW-1:0]   na, nb, nt;
  logic [FR_W-1:0] frame_l;

  always_comb begin
    pa = '0; na = '0; pb = '0; nb = '0;
    if (field_en[2]) begin
      pa = (pa << RMS_W) | CH_W'(a_rms); na = na + CW'(RMS_W);
      pb = (pb << RMS_W) | CH_W'(b_rms); nb = nb + CW'(RMS_W);
    end
    if (field_en[1]) begin
      pa = (pa << PK_W) | CH_W'(a_peak); na = na + CW'(PK_W);
      pb = (pb << PK_W) | CH_W'(b_peak); nb = nb + CW'(PK_W);
    end
    if (field_en[0]) begin
      pa = (pa << TH_W) | CH_W'(a_thr); na = na + CW'(TH_W);
      pb = (pb << TH_W) | CH_W'(b_thr); nb = nb + CW'(TH_W);
    end
    nt      = na + nb;
    frame_l = ((FR_W'(pa) << nb) | FR_W'(pb)) << (CW'(FR_W) - nt);
  end

  logic [1:0]      cnt, lim;
  logic            pend, act;
  logic [FR_W-1:0] sr;
  logic [CW-1:0]   left;

  assign lim  = (div_sel == 2'd0) ? 2'd0 : (div_sel == 2'd1) ? 2'd1 : 2'd3;
  wire tick   = (cnt == lim);
  wire rise   = tick & ~ser_clk;
  wire run    = ~sclk_sleep | pend | act;
  wire finish = rise & act & (left == '0);

  assign busy = pend | act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ser_clk <= 1'b0; ser_sync <= 1'b0; ser_data <= 1'b0;
      pend <= 1'b0; act <= 1'b0; sr <= '0; left <= '0;
    end else begin
      if (start && !pend && !act) begin
        pend <= 1'b1;
        sr   <= frame_l;
        left <= nt;
      end
      if (!run) begin
        cnt <= '0;
        ser_clk <= 1'b0;
      end else if (tick) begin
        cnt <= '0;
        ser_clk <= ~ser_clk & ~(finish & sclk_sleep);
      end else begin
        cnt <= cnt + 2'd1;
      end
      if (rise) begin
        if (pend) begin
          ser_sync <= 1'b1;
          pend <= 1'b0;
          act  <= 1'b1;
        end else if (act) begin
          ser_sync <= 1'b0;
          if (left != '0) begin
            ser_data <= sr[FR_W-1];
            sr   <= sr << 1;
            left <= left - CW'(1);
          end else begin
            act <= 1'b0;
            ser_data <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/monitor_frame_tx_chk.sv
module monitor_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sclk_sleep,
  input logic ser_clk,
  input logic ser_sync,
  input logic ser_data,
  input logic busy
);
  AST_DATA_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ser_data); // R10
  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (!$stable(ser_sync) || !$stable(ser_data))) |-> $rose(ser_clk)); // R2
  AST_SYNC_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ser_sync |-> busy); // R3
  AST_SLEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sclk_sleep && !busy) |=> !ser_clk); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R8
endmodule

bind monitor_frame_tx monitor_frame_tx_chk u_chk (.*);

// File: tb/monitor_frame_tx_bench.sv
module monitor_frame_tx_bench;
  localparam int FR = 104;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, sclk_sleep = 1'b0;
  logic [2:0] field_en = 3'b111;
  logic [1:0] div_sel = 2'd0;
  logic [19:0] a_rms, b_rms;
  logic [15:0] a_peak, a_thr, b_peak, b_thr;
  logic ser_clk, ser_sync, ser_data, busy;

  monitor_frame_tx u_monitor_frame_tx (.*);

  int checks = 0, errors = 0;
  logic prev_sclk = 1'b0, rose = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [FR-1:0] act, input logic [FR-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rose = ser_clk && !prev_sclk;
    prev_sclk = ser_clk;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin step(); n++; end while (!rose && n < 100);
  endtask

  task automatic set_vals();
    a_rms = 20'hA5C3E; a_peak = 16'h1234; a_thr = 16'h00F1;
    b_rms = 20'h53A71; b_peak = 16'hBEEF; b_thr = 16'h8001;
  endtask

  task automatic run_frame(input logic [2:0] en, input logic [1:0] dv,
                           input bit slp, input bit disturb);
    logic [FR-1:0] exp, got;
    logic [19:0] val;
    int nbits, n, k, per, w;
    bit sync_bad, busy_ok, quiet;
    set_vals();
    exp = '0; nbits = 0;
    for (int ch = 0; ch < 2; ch++)
      for (int f = 0; f < 3; f++)
        if (en[2-f]) begin
          w = (f == 0) ? 20 : 16;
          if (ch == 0) val = (f == 0) ? a_rms : (f == 1) ? {4'b0, a_peak} : {4'b0, a_thr};
          else         val = (f == 0) ? b_rms : (f == 1) ? {4'b0, b_peak} : {4'b0, b_thr};
          for (int j = w - 1; j >= 0; j--) begin exp[FR-1-nbits] = val[j]; nbits++; end
        end
    per = (dv == 2'd0) ? 2 : (dv == 2'd1) ? 4 : 8;
    field_en = en; div_sel = dv; sclk_sleep = slp;
    step(); step();
    start = 1'b1; step(); start = 1'b0;
    chk(busy, "R8", "busy after start", FR'(busy), FR'(1));
    wait_rise(n);
    chk(ser_sync && n < 100, "R3", "sync at first rise", FR'(ser_sync), FR'(1));
    got = '0; sync_bad = 0; busy_ok = 1;
    for (int i = 0; i < nbits; i++) begin
      wait_rise(n);
      if (i == 1) chk(n == per, "R1", "serial clock period", FR'(n), FR'(per));
      if (ser_sync) sync_bad = 1;
      got[FR-1-i] = ser_data;
      busy_ok &= busy;
      if (disturb && i == 5) begin
        a_rms = ~a_rms; a_peak = ~a_peak; a_thr = ~a_thr;
        b_rms = ~b_rms; b_peak = ~b_peak; b_thr = ~b_thr; field_en = ~en;
        start = 1'b1; step(); start = 1'b0;
      end
    end
    chk(!sync_bad, "R3", "sync low during data", FR'(sync_bad), FR'(0));
    chk(got == exp, "R4", "frame bits", got, exp);
    if (disturb) chk(got == exp, "R9", "snapshot kept", got, exp);
    chk(busy_ok, "R8", "busy through data", FR'(busy_ok), FR'(1));
    k = 0;
    while (busy && k < 40) begin step(); k++; end
    chk(!busy && k <= per + 1, en == 3'b000 ? "R5" : "R8", "busy falls after frame", FR'(k), FR'(per));
    chk(!ser_data, "R10", "data low when idle", FR'(ser_data), FR'(0));
    if (disturb) begin
      quiet = 1;
      for (int i = 0; i < 40; i++) begin step(); if (busy || ser_sync) quiet = 0; end
      chk(quiet, "R7", "no second frame", FR'(quiet), FR'(1));
    end
    field_en = 3'b111;
  endtask

  task automatic t_reset();
    chk({ser_clk, ser_sync, ser_data, busy} == 4'b0, "R10", "reset outputs",
        FR'({ser_clk, ser_sync, ser_data, busy}), FR'(0));
  endtask

  task automatic t_idle_sleep();
    bit low_ok = 1;
    sclk_sleep = 1'b1; step(); step(); step();
    for (int i = 0; i < 30; i++) begin step(); if (ser_clk) low_ok = 0; end
    chk(low_ok, "R6", "clock held low in sleep idle", FR'(low_ok), FR'(1));
  endtask

  task automatic t_idle_run();
    int r = 0;
    sclk_sleep = 1'b0; div_sel = 2'd0; step(); step();
    for (int i = 0; i < 32; i++) begin step(); if (rose) r++; end
    chk(r == 16, "R6", "clock runs when idle", FR'(r), FR'(16));
  endtask

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_vals();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_frame(3'b111, 2'd0, 1'b0, 1'b0);
    run_frame(3'b010, 2'd1, 1'b1, 1'b0);
    run_frame(3'b101, 2'd2, 1'b0, 1'b1);
    run_frame(3'b110, 2'd3, 1'b1, 1'b0);
    run_frame(3'b001, 2'd0, 1'b1, 1'b0);
    run_frame(3'b000, 2'd1, 1'b0, 1'b0);
    t_idle_sleep();
    t_idle_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule